// File: doc/BRIEF.md
# DMA Audio Playback Engine

This block plays 8-bit audio samples straight out of system memory. Software writes a 24-bit start address and a 24-bit end address into byte-wide registers, picks mono or stereo and one of four sample rates, and sets the run bit. The engine then reads 16-bit words over a simple request/grant memory port into a small word FIFO. It sends the samples to a left/right output pair with a strobe, one strobe for each sample period.

A frame runs from the start address up to, but not including, the end address. When the frame ends, the engine does one of two things. With the repeat bit set, it reloads the start address and keeps going. With the repeat bit clear, it clears the run bit, plays out the words it has already fetched and then falls silent. Each frame end can raise one-cycle pulses on two interrupt lines, and each line has its own enable bit. Address writes made during playback are staged and take effect only at the next frame boundary. The live fetch pointer can be read back as three bytes.

Top module: `dma_audio_player`

## Requirements
- R1: After reset, every register reads 0, `mem_req` and both interrupt lines are low, and the sample outputs and strobe are 0.
- R2: Writing control (register 0) with bit 0 = 1 while stopped copies the staged start address into the fetch pointer. The pointer reads back through registers 10 (bits 23:16), 11 (bits 15:8) and 12 (bits 7:0). The start address is register 4 (high), 5 (middle) and 6 (low). The end address is register 7 (high), 8 (middle) and 9 (low).
- R3: Words are fetched at ascending even addresses from the start address. `mem_addr` holds steady while `mem_req` waits for `mem_gnt`. Data is taken in the grant cycle, and the pointer moves on by 2 for each grant.
- R4: In stereo (mode register 1, bit 7 = 0), each strobe presents one word: bits 15:8 on the left output and bits 7:0 on the right output, in address order.
- R5: In mono (mode bit 7 = 1), each word gives two strobes, first bits 15:8 and then bits 7:0, with the same value on both outputs.
- R6: Strobes are exactly RATE_BASE × 2^(3−code) cycles apart, where code is mode bits 1:0 (3 is the fastest rate).
- R7: When the pointer reaches the end address with repeat (control bit 1) clear, control bit 0 reads 0 and fetching stops. Every word already fetched is still played. After that the outputs read 0, no further strobes appear, and the pointer reads the end address.
- R8: With repeat set, the pointer returns to the start address at each frame end without any software action.
- R9: Start and end addresses written during playback take effect only at a frame boundary. A frame is never cut short or extended by such a write.
- R10: Each frame end gives a one-cycle pulse on `irq_a` if bit 0 of register 2 is set, and on `irq_b` if bit 1 of register 2 is set.
- R11: If a sample is due while playing and the FIFO is empty, the outputs repeat the last sample, the strobe still pulses, and status bit 0 (register 3) is set and stays set. Writing 1 to that bit clears it.
- R12: Writing control bit 0 = 0 while playing empties the FIFO and drives both outputs to 0 on the next clock edge. No further strobes follow.
- R13: Bit 0 of the start-low and end-low registers is ignored and always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register index |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational on reg_addr) |
| mem_req | output | 1 | Word read request |
| mem_addr | output | 24 | Byte address of the requested word |
| mem_gnt | input | 1 | Grant; data is valid in the same cycle |
| mem_rdata | input | 16 | Read word |
| smp_left | output | 8 | Left channel sample |
| smp_right | output | 8 | Right channel sample |
| smp_strobe | output | 1 | One-cycle pulse when a new sample pair is presented |
| irq_a | output | 1 | Frame-end pulse, first line |
| irq_b | output | 1 | Frame-end pulse, second line |

## Verification
The run bit is written at one clock edge. Fetching starts in that same cycle, and the first strobe appears exactly one rate period later. The bench therefore never waits for a fixed delay to check sample order. It decodes the fetch address from every strobe, because the memory model returns address bits 16:1 as data, and it checks the gap between strobes against the rate period in cycles. A write that stops playback silences the outputs at the edge that takes the write, so the bench checks the outputs at the falling edge right after it. The end-of-frame checks wait at least four rate periods after the last expected strobe, then read the pointer and the run bit and compare the interrupt pulse counts.

// File: rtl/apu_pkg.sv
package apu_pkg;
   localparam int ADDR_W = 24;
   localparam int SMP_W  = 8;
   localparam int WORD_W = 2 * SMP_W;

   typedef enum logic [3:0] {
      RG_CTRL  = 4'd0,
      RG_MODE  = 4'd1,
      RG_IRQEN = 4'd2,
      RG_STAT  = 4'd3,
      RG_BEG_H = 4'd4,
      RG_BEG_M = 4'd5,
      RG_BEG_L = 4'd6,
      RG_FIN_H = 4'd7,
      RG_FIN_M = 4'd8,
      RG_FIN_L = 4'd9,
      RG_PTR_H = 4'd10,
      RG_PTR_M = 4'd11,
      RG_PTR_L = 4'd12
   } apu_reg_e;
endpackage

// File: rtl/apu_fifo.sv
module apu_fifo #(
   parameter int W     = 16,
   parameter int DEPTH = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         push,
   input  logic [W-1:0] wdata,
   input  logic         pop,
   output logic [W-1:0] rdata,
   output logic         empty,
   output logic         full
);
   localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = $clog2(DEPTH + 1);

   if (DEPTH < 2) begin : g_bad_depth
      $error("apu_fifo: DEPTH must be at least 2");
   end

   logic [W-1:0]  store [DEPTH];
   logic [PW-1:0] wp, rp, wp_n, rp_n;
   logic [CW-1:0] cnt;

   if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
      assign wp_n = wp + 1'b1;
      assign rp_n = rp + 1'b1;
   end else begin : g_mod
      assign wp_n = (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      assign rp_n = (rp == PW'(DEPTH - 1)) ? '0 : rp + 1'b1;
   end

   assign empty = (cnt == '0);
   assign full  = (cnt == CW'(DEPTH));
   assign rdata = store[rp];

   always_ff @(posedge clk) begin
      if (push) store[wp] <= wdata;
   end

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else begin
         if (push) wp <= wp_n;
         if (pop)  rp <= rp_n;
         case ({push, pop})
            2'b10:   cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: cnt <= cnt;
         endcase
      end
   end

   // R3
   fifo_no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (push && !clr) |-> !full);
   // R11
   fifo_no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && !clr) |-> !empty);
endmodule

// File: rtl/apu_rate_gen.sv
module apu_rate_gen #(
   parameter int BASE = 160
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       en,
   input  logic       clr,
   input  logic [1:0] code,
   output logic       tick
);
   localparam int MAXP = BASE * 8;
   localparam int CW   = $clog2(MAXP + 1);

   if (BASE < 2) begin : g_bad_base
      $error("apu_rate_gen: BASE must be at least 2");
   end

   logic [CW-1:0] cnt, period;

   assign period = CW'(BASE) << (2'd3 - code);
   assign tick   = en && (cnt >= period - CW'(1));

   always_ff @(posedge clk) begin
      if (!rst_n || clr || !en) cnt <= '0;
      else if (tick)            cnt <= '0;
      else                      cnt <= cnt + 1'b1;
   end

   // R6
   tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick);
endmodule

// File: rtl/apu_fetch.sv
module apu_fetch #(
   parameter int AW = 24
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          go,
   input  logic          halt,
   input  logic          repeat_en,
   input  logic [AW-1:0] stage_beg,
   input  logic [AW-1:0] stage_fin,
   input  logic          room,
   input  logic          mem_gnt,
   output logic          mem_req,
   output logic [AW-1:0] mem_addr,
   output logic [AW-1:0] cur_addr,
   output logic          frame_end,
   output logic          active
);
   logic [AW-1:0] cur, fin_sh;

   assign frame_end = active && (cur == fin_sh);
   assign mem_req   = active && !frame_end && room;
   assign mem_addr  = cur;
   assign cur_addr  = cur;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active <= 1'b0;
         cur    <= '0;
         fin_sh <= '0;
      end else if (go) begin
         active <= 1'b1;
         cur    <= stage_beg;
         fin_sh <= stage_fin;
      end else if (halt) begin
         active <= 1'b0;
      end else if (frame_end) begin
         if (repeat_en) begin
            cur    <= stage_beg;
            fin_sh <= stage_fin;
         end else begin
            active <= 1'b0;
         end
      end else if (mem_req && mem_gnt) begin
         cur <= cur + AW'(2);
      end
   end

   // R3
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_gnt && !halt) |=> (mem_req && $stable(mem_addr)));
   // R3
   ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_gnt) |=> (cur_addr == $past(cur_addr) + AW'(2)));
   // R7
   stop_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_end && !repeat_en && !go) |=> !active);
endmodule

// File: rtl/apu_output.sv
module apu_output #(
   parameter int SW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          flush,
   input  logic          playing,
   input  logic          mono,
   input  logic          tick,
   input  logic          fifo_empty,
   input  logic [2*SW-1:0] word,
   output logic          pop,
   output logic          busy,
   output logic          underrun,
   output logic [SW-1:0] left,
   output logic [SW-1:0] right,
   output logic          strobe
);
   logic          half;
   logic [SW-1:0] hold;
   logic          need;
   logic [SW-1:0] w_hi, w_lo;

   assign w_hi     = word[2*SW-1:SW];
   assign w_lo     = word[SW-1:0];
   assign busy     = playing || !fifo_empty || half;
   assign need     = tick && !half;
   assign pop      = need && !fifo_empty && !flush;
   assign underrun = need && fifo_empty && playing && !flush;

   always_ff @(posedge clk) begin
      if (!rst_n || flush || !busy) begin
         half   <= 1'b0;
         hold   <= '0;
         left   <= '0;
         right  <= '0;
         strobe <= 1'b0;
      end else begin
         strobe <= tick;
         if (tick) begin
            if (half) begin
               left  <= hold;
               right <= hold;
               half  <= 1'b0;
            end else if (!fifo_empty) begin
               if (mono) begin
                  left  <= w_hi;
                  right <= w_hi;
                  hold  <= w_lo;
                  half  <= 1'b1;
               end else begin
                  left  <= w_hi;
                  right <= w_lo;
               end
            end
         end
      end
   end

   // R11
   repeat_on_underrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
      underrun |=> (strobe && $stable(left) && $stable(right)));
   // R5
   mono_equal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && mono && !flush && busy && !fifo_empty) |=> (left == right));
endmodule

// File: rtl/dma_audio_player.sv
module dma_audio_player
   import apu_pkg::*;
#(
   parameter int FIFO_DEPTH = 4,
   parameter int RATE_BASE  = 160
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        reg_we,
   input  logic [3:0]  reg_addr,
   input  logic [7:0]  reg_wdata,
   output logic [7:0]  reg_rdata,
   output logic        mem_req,
   output logic [23:0] mem_addr,
   input  logic        mem_gnt,
   input  logic [15:0] mem_rdata,
   output logic [7:0]  smp_left,
   output logic [7:0]  smp_right,
   output logic        smp_strobe,
   output logic        irq_a,
   output logic        irq_b
);
   if (ADDR_W != 24 || WORD_W != 16) begin : g_bad_pkg
      $error("dma_audio_player: register map assumes 24-bit addresses and 16-bit words");
   end

   logic              rep_en, mono, ufl_sticky;
   logic [1:0]        rate_code, irq_en;
   logic [ADDR_W-1:0] stage_beg, stage_fin, cur_addr;
   logic              running, frame_end, go, halt, flush;
   logic              fifo_empty, fifo_full, pop, busy, tick, underrun;
   logic [WORD_W-1:0] fifo_word;
   logic              wr_ctrl;

   assign wr_ctrl = reg_we && (reg_addr == RG_CTRL);
   assign go      = wr_ctrl && reg_wdata[0] && !running;
   assign halt    = wr_ctrl && !reg_wdata[0] && running;
   assign flush   = go || halt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rep_en     <= 1'b0;
         mono       <= 1'b0;
         rate_code  <= 2'd0;
         irq_en     <= 2'd0;
         stage_beg  <= '0;
         stage_fin  <= '0;
         ufl_sticky <= 1'b0;
      end else begin
         if (underrun) ufl_sticky <= 1'b1;
         if (reg_we) begin
            case (reg_addr)
               RG_CTRL:  rep_en <= reg_wdata[1];
               RG_MODE:  begin
                  mono      <= reg_wdata[7];
                  rate_code <= reg_wdata[1:0];
               end
               RG_IRQEN: irq_en <= reg_wdata[1:0];
               RG_STAT:  if (reg_wdata[0] && !underrun) ufl_sticky <= 1'b0;
               RG_BEG_H: stage_beg[23:16] <= reg_wdata;
               RG_BEG_M: stage_beg[15:8]  <= reg_wdata;
               RG_BEG_L: stage_beg[7:0]   <= {reg_wdata[7:1], 1'b0};
               RG_FIN_H: stage_fin[23:16] <= reg_wdata;
               RG_FIN_M: stage_fin[15:8]  <= reg_wdata;
               RG_FIN_L: stage_fin[7:0]   <= {reg_wdata[7:1], 1'b0};
               default:  ;
            endcase
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         irq_a <= 1'b0;
         irq_b <= 1'b0;
      end else begin
         irq_a <= frame_end && irq_en[0];
         irq_b <= frame_end && irq_en[1];
      end
   end

   always_comb begin
      case (reg_addr)
         RG_CTRL:  reg_rdata = {6'd0, rep_en, running};
         RG_MODE:  reg_rdata = {mono, 5'd0, rate_code};
         RG_IRQEN: reg_rdata = {6'd0, irq_en};
         RG_STAT:  reg_rdata = {7'd0, ufl_sticky};
         RG_BEG_H: reg_rdata = stage_beg[23:16];
         RG_BEG_M: reg_rdata = stage_beg[15:8];
         RG_BEG_L: reg_rdata = stage_beg[7:0];
         RG_FIN_H: reg_rdata = stage_fin[23:16];
         RG_FIN_M: reg_rdata = stage_fin[15:8];
         RG_FIN_L: reg_rdata = stage_fin[7:0];
         RG_PTR_H: reg_rdata = cur_addr[23:16];
         RG_PTR_M: reg_rdata = cur_addr[15:8];
         RG_PTR_L: reg_rdata = cur_addr[7:0];
         default:  reg_rdata = 8'd0;
      endcase
   end

   apu_fetch #(.AW(ADDR_W)) u_fetch (
      .clk       (clk),
      .rst_n     (rst_n),
      .go        (go),
      .halt      (halt),
      .repeat_en (rep_en),
      .stage_beg (stage_beg),
      .stage_fin (stage_fin),
      .room      (!fifo_full),
      .mem_gnt   (mem_gnt),
      .mem_req   (mem_req),
      .mem_addr  (mem_addr),
      .cur_addr  (cur_addr),
      .frame_end (frame_end),
      .active    (running)
   );

   apu_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (flush),
      .push  (mem_req && mem_gnt),
      .wdata (mem_rdata),
      .pop   (pop),
      .rdata (fifo_word),
      .empty (fifo_empty),
      .full  (fifo_full)
   );

   apu_rate_gen #(.BASE(RATE_BASE)) u_rate (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (busy),
      .clr   (flush),
      .code  (rate_code),
      .tick  (tick)
   );

   apu_output #(.SW(SMP_W)) u_out (
      .clk        (clk),
      .rst_n      (rst_n),
      .flush      (flush),
      .playing    (running),
      .mono       (mono),
      .tick       (tick),
      .fifo_empty (fifo_empty),
      .word       (fifo_word),
      .pop        (pop),
      .busy       (busy),
      .underrun   (underrun),
      .left       (smp_left),
      .right      (smp_right),
      .strobe     (smp_strobe)
   );

   // R10
   irq_needs_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_a || irq_b) |-> $past(frame_end));
   // R12
   halt_silence_chk: assert property (@(posedge clk) disable iff (!rst_n)
      halt |=> (smp_left == 8'd0 && smp_right == 8'd0 && !smp_strobe));
endmodule

// File: tb/tb_dma_audio_player.sv
module tb_dma_audio_player;
   localparam int RB = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [3:0]  reg_addr = 4'd0;
   logic [7:0]  reg_wdata = 8'd0;
   logic [7:0]  reg_rdata;
   logic        mem_req, mem_gnt;
   logic [23:0] mem_addr;
   logic [15:0] mem_rdata;
   logic [7:0]  smp_left, smp_right;
   logic        smp_strobe, irq_a, irq_b;

   int n_chk = 0, n_bad = 0, cyc = 0;
   int gnt_mode = 0, budget = 0;

   // monitor state
   bit          mon_on = 0, mon_mono = 0, have_prev = 0, phase = 0;
   bit          at_bound = 0, pend_on = 0, switched = 0;
   int          mon_per = 0, prev_cyc = 0, n_strobe = 0, n_frames = 0;
   int          n_irq_a = 0, n_irq_b = 0;
   logic [23:0] exp_addr = 0, exp_beg = 0, exp_fin = 0, pend_beg = 0, pend_fin = 0;
   logic [7:0]  hi_byte = 0;

   always #5 clk = ~clk;

   always @(posedge clk) cyc <= cyc + 1;

   assign mem_gnt = mem_req && ((gnt_mode == 0) || (gnt_mode == 1 && cyc[0]) ||
                                (gnt_mode == 2 && budget > 0));
   assign mem_rdata = mem_addr[16:1];

   always @(posedge clk) if (mem_gnt && gnt_mode == 2) budget <= budget - 1;

   dma_audio_player #(.FIFO_DEPTH(4), .RATE_BASE(RB)) dut (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
      .mem_addr(mem_addr), .mem_gnt(mem_gnt), .mem_rdata(mem_rdata),
      .smp_left(smp_left), .smp_right(smp_right), .smp_strobe(smp_strobe),
      .irq_a(irq_a), .irq_b(irq_b));

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
      end
   endtask

   task automatic check_word(input logic [23:0] a, input string tag);
      if (at_bound) n_frames++;
      if (at_bound && pend_on && a == pend_beg) begin
         exp_beg  = pend_beg;
         exp_fin  = pend_fin;
         exp_addr = pend_beg;
         pend_on  = 0;
         switched = 1;
      end
      chk(a == exp_addr, at_bound ? "R8/R9 frame restart address" : tag, a, exp_addr);
      exp_addr = exp_addr + 24'd2;
      at_bound = 0;
      if (exp_addr == exp_fin) begin
         exp_addr = exp_beg;
         at_bound = 1;
      end
   endtask

   always @(negedge clk) begin
      if (irq_a) n_irq_a++;
      if (irq_b) n_irq_b++;
      if (smp_strobe) begin
         n_strobe++;
         if (mon_per != 0 && have_prev)
            chk(cyc - prev_cyc == mon_per, "R6 strobe spacing", cyc - prev_cyc, mon_per);
         have_prev = 1;
         prev_cyc  = cyc;
         if (mon_on) begin
            if (!mon_mono) begin
               check_word({7'd0, smp_left, smp_right, 1'b0}, "R4 stereo word order");
            end else begin
               chk(smp_left == smp_right, "R5 mono channels equal", smp_right, smp_left);
               if (!phase) begin
                  hi_byte = smp_left;
                  phase   = 1;
               end else begin
                  check_word({7'd0, hi_byte, smp_left, 1'b0}, "R5 mono byte order");
                  phase = 0;
               end
            end
         end
      end
   end

   task automatic wr(input logic [3:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [7:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic rd_ptr(output logic [23:0] p);
      logic [7:0] h, m, l;
      rd(4'd10, h); rd(4'd11, m); rd(4'd12, l);
      p = {h, m, l};
   endtask

   task automatic set_frame(input logic [23:0] b, input logic [23:0] f, input bit odd_low);
      wr(4'd4, b[23:16]); wr(4'd5, b[15:8]); wr(4'd6, b[7:0] | {7'd0, odd_low});
      wr(4'd7, f[23:16]); wr(4'd8, f[15:8]); wr(4'd9, f[7:0] | {7'd0, odd_low});
   endtask

   task automatic arm_monitor(input logic [23:0] b, input logic [23:0] f, input bit mono, input int per);
      exp_addr = b; exp_beg = b; exp_fin = f;
      mon_mono = mono; mon_per = per; have_prev = 0; phase = 0;
      at_bound = 0; pend_on = 0; switched = 0; n_strobe = 0; n_frames = 0;
      n_irq_a = 0; n_irq_b = 0; mon_on = 1;
   endtask

   task automatic play_once(input bit mono, input int code, input logic [1:0] en, input logic [23:0] base);
      int nw, need, per;
      logic [23:0] fin, p;
      logic [7:0]  d;
      nw   = 6;
      per  = RB << (3 - code);
      need = mono ? 2 * nw : nw;
      fin  = base + 24'(2 * nw);
      gnt_mode = code[0];
      wr(4'd1, {mono, 5'd0, 2'(code)});
      wr(4'd2, {6'd0, en});
      set_frame(base, fin, code == 1);
      if (code == 1) begin
         rd(4'd6, d);
         chk(d == base[7:0], "R13 start low bit 0 ignored", d, base[7:0]);
         rd(4'd9, d);
         chk(d == fin[7:0], "R13 end low bit 0 ignored", d, fin[7:0]);
      end
      arm_monitor(base, fin, mono, per);
      wr(4'd0, 8'h01);
      for (int i = 0; i < need * per * 2 + 100 && n_strobe < need; i++) @(negedge clk);
      repeat (4 * per) @(negedge clk);
      chk(n_strobe == need, "R7 strobe count for one frame", n_strobe, need);
      chk(smp_left == 0 && smp_right == 0, "R7 silence after drain",
          {smp_left, smp_right}, 0);
      chk(!mem_req, "R7 no request after end", mem_req, 0);
      rd(4'd0, d);
      chk(d[0] == 1'b0, "R7 run bit cleared by hardware", d[0], 0);
      rd_ptr(p);
      chk(p == fin, "R7 pointer reads end address", p, fin);
      chk(n_irq_a == int'(en[0]), "R10 irq_a pulses", n_irq_a, en[0]);
      chk(n_irq_b == int'(en[1]), "R10 irq_b pulses", n_irq_b, en[1]);
      mon_on = 0;
   endtask

   initial begin
      logic [7:0]  d;
      logic [23:0] p;
      int          s0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      for (int a = 0; a < 13; a++) begin
         rd(4'(a), d);
         chk(d == 8'd0, "R1 register reset value", d, 0);
      end
      chk(!mem_req && !irq_a && !irq_b && !smp_strobe && smp_left == 0 && smp_right == 0,
          "R1 outputs idle after reset", {mem_req, irq_a, irq_b, smp_strobe}, 0);

      // sweep: mono/stereo x four rates, irq enable pattern follows the rate code
      for (int m = 0; m < 2; m++)
         for (int c = 0; c < 4; c++)
            play_once(m[0], c, 2'(c), 24'h001000 + 24'(m * 24'h400 + c * 24'h100));

      // R11 / R2 / R3 underflow with a stalled memory
      gnt_mode = 2; budget = 0;
      wr(4'd1, 8'h03);
      wr(4'd2, 8'h00);
      set_frame(24'h012340, 24'h012380, 0);
      mon_on = 0; mon_per = 0; n_strobe = 0;
      wr(4'd0, 8'h01);
      rd_ptr(p);
      chk(p == 24'h012340, "R2 pointer loaded from start", p, 24'h012340);
      chk(mem_req && mem_addr == 24'h012340, "R3 first request address", mem_addr, 24'h012340);
      repeat (5) @(negedge clk);
      chk(mem_req && mem_addr == 24'h012340, "R3 address held while waiting", mem_addr, 24'h012340);
      budget = 1;
      n_strobe = 0;
      for (int i = 0; i < 200 && n_strobe < 4; i++) @(negedge clk);
      chk(n_strobe >= 4, "R11 strobes continue on underrun", n_strobe, 4);
      chk({smp_left, smp_right} == 16'h91A0, "R11 last sample repeated",
          {smp_left, smp_right}, 16'h91A0);
      rd(4'd3, d);
      chk(d[0] == 1'b1, "R11 sticky underrun bit", d[0], 1);
      rd_ptr(p);
      chk(p == 24'h012342, "R3 pointer advanced by 2 per grant", p, 24'h012342);
      wr(4'd0, 8'h00);
      chk(smp_left == 0 && smp_right == 0, "R12 silence after software stop",
          {smp_left, smp_right}, 0);
      s0 = n_strobe;
      repeat (40) @(negedge clk);
      chk(n_strobe == s0, "R12 no strobes after stop", n_strobe, s0);
      wr(4'd3, 8'h01);
      rd(4'd3, d);
      chk(d[0] == 1'b0, "R11 sticky bit cleared by writing 1", d[0], 0);

      // R8 / R9 / R10 repeat with staged frame change
      gnt_mode = 0;
      wr(4'd1, 8'h03);
      wr(4'd2, 8'h03);
      set_frame(24'h000200, 24'h000220, 0);
      arm_monitor(24'h000200, 24'h000220, 0, RB);
      wr(4'd0, 8'h03);
      for (int i = 0; i < 2000 && n_frames < 2; i++) @(negedge clk);
      chk(n_frames >= 2, "R8 frame restarted without software", n_frames, 2);
      pend_beg = 24'h0002A0; pend_fin = 24'h0002B0; pend_on = 1;
      wr(4'd9, 8'hB0);
      wr(4'd6, 8'hA0);
      s0 = n_strobe;
      for (int i = 0; i < 3000 && n_strobe < s0 + 40; i++) @(negedge clk);
      chk(switched, "R9 staged frame taken at a boundary", switched, 1);
      chk(n_irq_a == n_irq_b && n_irq_a >= 3, "R10 one pulse per frame on each line",
          n_irq_a, n_irq_b);
      rd(4'd0, d);
      chk(d[1:0] == 2'b11, "R8 still running in repeat", d[1:0], 3);
      mon_on = 0;
      wr(4'd0, 8'h00);
      chk(smp_left == 0 && smp_right == 0, "R12 silence after stop in repeat",
          {smp_left, smp_right}, 0);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   always @(posedge clk) begin
      if (cyc > 150000) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog expired actual=%0d expected=<150000", cyc);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule